// File: doc/BRIEF.md
# Grouped Interrupt Request Expander

This block gathers a bank of peripheral interrupt request lines, arranged as twelve groups of eight, and folds each group onto a single CPU interrupt output. Each group has two registers. The flag register latches incoming requests. The enable register selects which latched requests may go forward.

A per-group throttle bit holds back further requests from a group once that group has reached the CPU. The throttle bit is set by hardware when a group's request is sent. Software clears it by writing 1.

When the CPU takes an interrupt, it presents the group number and strobes an acknowledge. The block does three things:
- It points at the vector-table entry of the highest-priority pending line in that group.
- It clears that line's flag on the acknowledge strobe.
- It returns a fixed default vector if vector fetch is switched off or nothing in the group is pending.

A flat register port gives software write access and combinational read access to everything.

Top module: `grp_irq_expander`

## Requirements
- R1: A high level on request line `irq_in[g*8+y]` at a rising edge sets bit y of the flag register of group g, which reads back at address 16+g.
- R2: A flagged line whose enable bit (enable register of group g, address 32+g, bit y) is clear never drives `cpu_int`. Setting the enable bit later lets the still-set flag through.
- R3: When group g holds an enabled flagged line and its throttle bit is clear at an edge, `cpu_int[g]` is high for exactly the following cycle. The throttle bit g is set at that same edge.
- R4: While throttle bit g is set, `cpu_int[g]` stays low. After software writes 1 to bit g of the throttle register (address 1), a still-pending enabled request raises `cpu_int[g]` one edge after the clearing edge.
- R5: Writing 0 to a throttle bit has no effect on it.
- R6: On `cpu_ack` with `cpu_ack_grp`=g, the flag of the lowest-numbered enabled flagged line in group g is cleared, and no other flag of the group is cleared.
- R7: With control bit 0 set, `vec_addr` = {control[15:1],0} + g*8 + y, where g is `cpu_ack_grp` and y is the winning line of that group.
- R8: `vec_addr` equals the default vector 16'hFFF0 when control bit 0 is clear or group `cpu_ack_grp` has no enabled flagged line.
- R9: After reset, all flag, enable, throttle and control registers read 0 and `cpu_int` is 0.
- R10: The control register (address 0) and enable registers read back the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 96 | Peripheral request lines, group-major |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data (combinational) |
| cpu_int | output | 12 | One CPU interrupt per group |
| cpu_ack | input | 1 | CPU acknowledge strobe |
| cpu_ack_grp | input | 4 | Group being serviced |
| vec_addr | output | 16 | Vector-table address for the serviced group |

## Verification
A request seen at edge E is readable in its flag register right after E. If it is enabled and unthrottled, `cpu_int` rises after edge E+1 and falls after E+2.

An enable or throttle-clear write that lands at edge E takes effect on `cpu_int` only after E+1. `vec_addr` and `rdata` follow their inputs in the same cycle.

The bench drives every input on the falling clock edge and samples at the next falling edge. It waits the exact number of edges listed above, so a result that comes one cycle early or one cycle late is caught.

// File: rtl/grp_irq_expander.sv
module grp_irq_expander #(
  parameter int NGRP = 12,
  parameter int NLINE = 8,
  parameter int DW = 16,
  parameter int AW = 6,
  parameter logic [15:0] DEF_VEC = 16'hFFF0,
  localparam int GW = $clog2(NGRP),
  localparam int LW = $clog2(NLINE)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NGRP*NLINE-1:0]  irq_in,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic [NGRP-1:0]        cpu_int,
  input  logic                   cpu_ack,
  input  logic [GW-1:0]          cpu_ack_grp,
  output logic [DW-1:0]          vec_addr
);
  localparam int ACK_ADDR = 1;
  localparam int FLAG_BASE = 16;
  localparam int EN_BASE = 32;

  logic [NLINE-1:0] flag_q [NGRP];
  logic [NLINE-1:0] en_q   [NGRP];
  logic [NLINE-1:0] flag_nxt [NGRP];
  logic [LW-1:0]    win_line [NGRP];
  logic [NGRP-1:0]  pend_any, ack_q, int_q, fire, ack_clr;
  logic [DW-1:0]    ctrl_q;
  logic             sel_any;
  logic [LW-1:0]    sel_line;

  assign fire    = pend_any & ~ack_q;
  assign ack_clr = (wr_en && addr == AW'(ACK_ADDR)) ? wdata[NGRP-1:0] : '0;
  assign cpu_int = int_q;

  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      pend_any[g] = |(flag_q[g] & en_q[g]);
      win_line[g] = '0;
      for (int l = NLINE-1; l >= 0; l--)
        if (flag_q[g][l] && en_q[g][l]) win_line[g] = LW'(l);
      flag_nxt[g] = flag_q[g];
      if (wr_en && addr == AW'(FLAG_BASE + g)) flag_nxt[g] = wdata[NLINE-1:0];
      if (cpu_ack && cpu_ack_grp == GW'(g) && pend_any[g]) flag_nxt[g][win_line[g]] = 1'b0;
      flag_nxt[g] = flag_nxt[g] | irq_in[g*NLINE +: NLINE];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NGRP; g++) begin
        flag_q[g] <= '0;
        en_q[g]   <= '0;
      end
      ack_q  <= '0;
      int_q  <= '0;
      ctrl_q <= '0;
    end else begin
      for (int g = 0; g < NGRP; g++) begin
        flag_q[g] <= flag_nxt[g];
        if (wr_en && addr == AW'(EN_BASE + g)) en_q[g] <= wdata[NLINE-1:0];
      end
      if (wr_en && addr == '0) ctrl_q <= wdata;
      ack_q <= (ack_q & ~ack_clr) | fire;
      int_q <= fire;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata = ctrl_q;
    if (addr == AW'(ACK_ADDR)) rdata = DW'(ack_q);
    for (int g = 0; g < NGRP; g++) begin
      if (addr == AW'(FLAG_BASE + g)) rdata = DW'(flag_q[g]);
      if (addr == AW'(EN_BASE + g)) rdata = DW'(en_q[g]);
    end
  end

  always_comb begin
    sel_any = 1'b0;
    sel_line = '0;
    for (int g = 0; g < NGRP; g++)
      if (cpu_ack_grp == GW'(g)) begin
        sel_any = pend_any[g];
        sel_line = win_line[g];
      end
  end

  assign vec_addr = (ctrl_q[0] && sel_any)
                  ? {ctrl_q[DW-1:1], 1'b0} + DW'(cpu_ack_grp) * DW'(NLINE) + DW'(sel_line)
                  : DEF_VEC;
endmodule

module grp_irq_expander_chk #(parameter int NGRP = 12) (
  input logic            clk,
  input logic            rst_n,
  input logic [NGRP-1:0] cpu_int,
  input logic [NGRP-1:0] ack_q,
  input logic [NGRP-1:0] pend_any
);
  for (genvar g = 0; g < NGRP; g++) begin : gchk
    // R3
    int_sets_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_int[g] |-> ack_q[g]);
    // R3
    one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_int[g] |=> !cpu_int[g]);
    // R4
    held_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_int[g] |-> !$past(ack_q[g]));
    // R2
    needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_int[g] |-> $past(pend_any[g]));
  end
endmodule

bind grp_irq_expander grp_irq_expander_chk #(.NGRP(NGRP)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_int(cpu_int), .ack_q(ack_q), .pend_any(pend_any));

// File: tb/grp_irq_expander_tb_top.sv
`timescale 1ns/1ps
module grp_irq_expander_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, cpu_ack = 0;
  logic [95:0] irq_in = '0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0, rdata, vec_addr;
  logic [11:0] cpu_int;
  logic [3:0] cpu_ack_grp = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  grp_irq_expander dut_i (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cpu_int(cpu_int), .cpu_ack(cpu_ack),
    .cpu_ack_grp(cpu_ack_grp), .vec_addr(vec_addr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    addr = a; #0.2; d = rdata;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R9 cpu_int", 32'(cpu_int), 0);
    rd(0, d);  chk("R9 control", 32'(d), 0);
    rd(1, d);  chk("R9 throttle", 32'(d), 0);
    rd(18, d); chk("R9 flag", 32'(d), 0);
    rd(34, d); chk("R9 enable", 32'(d), 0);
  endtask

  task automatic t_flag_gate;
    logic [15:0] d;
    @(negedge clk); irq_in[19] = 1;
    @(negedge clk); irq_in[19] = 0;
    rd(18, d); chk("R1 flag set", 32'(d), 32'h08);
    repeat (3) @(negedge clk);
    chk("R2 disabled line quiet", 32'(cpu_int), 0);
    wr(34, 16'h0008);
    chk("R2 not yet", 32'(cpu_int), 0);
    @(negedge clk);
    chk("R3 int raised", 32'(cpu_int), 32'h004);
    rd(1, d); chk("R3 throttle set", 32'(d), 32'h004);
    @(negedge clk);
    chk("R3 one cycle", 32'(cpu_int), 0);
    rd(34, d); chk("R10 enable readback", 32'(d), 32'h08);
  endtask

  task automatic t_throttle;
    logic [15:0] d;
    wr(34, 16'h0028);
    @(negedge clk); irq_in[21] = 1;
    @(negedge clk); irq_in[21] = 0;
    repeat (3) begin
      @(negedge clk); chk("R4 held", 32'(cpu_int), 0);
    end
    wr(1, 16'h0000);
    rd(1, d); chk("R5 write 0 no effect", 32'(d), 32'h004);
    chk("R5 still held", 32'(cpu_int), 0);
    wr(1, 16'h0004);
    rd(1, d); chk("R4 cleared", 32'(d), 0);
    chk("R4 not yet", 32'(cpu_int), 0);
    @(negedge clk);
    chk("R4 released", 32'(cpu_int), 32'h004);
    @(negedge clk);
    chk("R3 pulse ends", 32'(cpu_int), 0);
  endtask

  task automatic t_prio_vec;
    logic [15:0] d;
    wr(0, 16'h1001);
    rd(0, d); chk("R10 control readback", 32'(d), 32'h1001);
    cpu_ack_grp = 2; #0.2;
    chk("R7 vector line 3", 32'(vec_addr), 32'h1013);
    @(negedge clk); cpu_ack = 1;
    @(negedge clk); cpu_ack = 0;
    rd(18, d); chk("R6 lowest cleared", 32'(d), 32'h20);
    chk("R7 vector line 5", 32'(vec_addr), 32'h1015);
    cpu_ack_grp = 5; #0.2;
    chk("R8 empty group", 32'(vec_addr), 32'hFFF0);
    cpu_ack_grp = 2;
    wr(0, 16'h1000);
    chk("R8 fetch off", 32'(vec_addr), 32'hFFF0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_flag_gate();
    t_throttle();
    t_prio_vec();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule